// File: doc/BRIEF.md
# Cacheability Region Decoder

The block decides, for every memory address presented to it, whether the secondary cache may hold that location. It compares the address with a programmable upper bound for cacheable local memory and with a fixed video BIOS window. It also checks two independent programmable non-cacheable blocks. If any of these excludes the address, the block raises a registered non-cacheable flag one clock after the address strobe. An active-low copy of the flag drives the external cache control pin.

The cacheable bound is programmed in 4 MB steps. Its zero code stands for the full 64 MB space. When the system holds only 1 MB or 2 MB of memory, the installed size overrides the bound. Each non-cacheable block has a power-of-two size from 64 KB to 512 KB, or is switched off. The base of a block is pulled down to a multiple of its size by ignoring low base bits. Configuration values arrive as static inputs. Register access, tags and the cache itself live elsewhere.

Top module: `cache_region_decode`

## Requirements
- R1: With `mem_sel` at 00 or 11 and `limit_code` N in 1..15, an address is inside the cacheable bound exactly when it is below N*4 MB. With N = 0, every address of the 64 MB space is inside the bound. An address outside the bound is non-cacheable.
- R2: `mem_sel` = 01 limits the cacheable bound to the first 1 MB, and `mem_sel` = 10 limits it to the first 2 MB, whatever `limit_code` holds.
- R3: While `vbios_nc` is 1, addresses 0xC0000 through 0xC7FFF are non-cacheable. While it is 0, that window is treated like any other address.
- R4: Bits 7:5 of a block control byte select the block size: codes 000, 001, 010 and 011 give 64 KB, 128 KB, 256 KB and 512 KB. Any code with bit 7 set turns the block off, so it excludes no address.
- R5: The block base is address bits 25:24 taken from control bits 1:0, followed by address bits 23:16 taken from the base byte. The low log2(size/64 KB) bits of this 10-bit base are ignored, so the block covers the aligned size-sized region that contains the programmed base.
- R6: There are two blocks with identical layout, each programmed independently. An address that hits either enabled block is non-cacheable.
- R7: `out_valid` and `nc_flag` are registered. One clock after a cycle with `addr_valid` high, `out_valid` is 1 and `nc_flag` holds the decision for that address. After a cycle with `addr_valid` low, `out_valid` is 0 and `nc_flag` keeps its previous value.
- R8: `nc_n` equals NOT(`nc_flag` AND `nc_pin_en`). While `nc_pin_en` is 0 the pin stays high, but `nc_flag` is still evaluated.
- R9: After reset, `out_valid` is 0, `nc_flag` is 0 and `nc_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_valid | input | 1 | Address strobe |
| addr | input | 26 | Byte address |
| limit_code | input | 4 | Cacheable bound in 4 MB steps, 0 = 64 MB |
| mem_sel | input | 2 | Installed memory: 01 = 1 MB, 10 = 2 MB, others = use bound |
| vbios_nc | input | 1 | Exclude the video BIOS window |
| blk_ctl | input | 2x8 | Per block: size code in 7:5, base bits 25:24 in 1:0 |
| blk_base | input | 2x8 | Per block: base bits 23:16 |
| nc_pin_en | input | 1 | Enable for the non-cacheable pin |
| out_valid | output | 1 | Decision valid |
| nc_flag | output | 1 | Registered non-cacheable decision |
| nc_n | output | 1 | Active-low non-cacheable pin |

## Verification
The bench builds the block with its default parameters: a 26-bit address, 64 KB pages and two blocks. At these values the page space has only 1024 entries, so each sweep covers every page rather than a sample. One sweep crosses all 16 bound codes and all four installed-memory settings with every page, using in-window and out-of-window offsets for the video BIOS test. A second sweep runs all eight size codes over both blocks with unaligned bases. This puts every alignment mask, the disable codes and the block edges within reach of exact arithmetic checks.

// File: rtl/cache_region_decode.sv
module cache_region_decode #(
  parameter int ADDR_W   = 26,
  parameter int PAGE_LSB = 16,
  parameter int STEP_LSB = 22,
  parameter int NUM_BLK  = 2,
  parameter int VB_LSB   = 15,
  parameter logic [ADDR_W-1:0] VB_BASE = 26'h00C0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          addr_valid,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [ADDR_W-STEP_LSB-1:0]    limit_code,
  input  logic [1:0]                    mem_sel,
  input  logic                          vbios_nc,
  input  logic [NUM_BLK-1:0][7:0]       blk_ctl,
  input  logic [NUM_BLK-1:0][7:0]       blk_base,
  input  logic                          nc_pin_en,
  output logic                          out_valid,
  output logic                          nc_flag,
  output logic                          nc_n
);
  localparam int PAGE_W = ADDR_W - PAGE_LSB;
  localparam int STEP_SH = STEP_LSB - PAGE_LSB;
  localparam int HI_W = PAGE_W - 8;
  localparam int VB_W = ADDR_W - VB_LSB;
  localparam logic [VB_W-1:0] VB_TAG = VB_BASE[ADDR_W-1:VB_LSB];

  logic [PAGE_W-1:0] page;
  logic in_limit, in_vb, nc_next;
  logic [NUM_BLK-1:0] blk_hit;

  assign page = addr[ADDR_W-1:PAGE_LSB];

  always_comb begin
    unique case (mem_sel)
      2'b01:   in_limit = (page[PAGE_W-1:4] == '0);
      2'b10:   in_limit = (page[PAGE_W-1:5] == '0);
      default: in_limit = (limit_code == '0) || (page[PAGE_W-1:STEP_SH] < limit_code);
    endcase
  end

  assign in_vb = vbios_nc && (addr[ADDR_W-1:VB_LSB] == VB_TAG);

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
    logic [2:0]        szc;
    logic [PAGE_W-1:0] base, mask;
    assign szc  = blk_ctl[i][7:5];
    assign base = {blk_ctl[i][HI_W-1:0], blk_base[i]};
    assign mask = {PAGE_W{1'b1}} << szc[1:0];
    assign blk_hit[i] = !szc[2] && (((page ^ base) & mask) == '0);
  end

  assign nc_next = !in_limit || in_vb || (|blk_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      nc_flag   <= 1'b0;
    end else begin
      out_valid <= addr_valid;
      if (addr_valid) nc_flag <= nc_next;
    end
  end

  assign nc_n = !(nc_flag && nc_pin_en);
endmodule

module cache_region_decode_chk #(
  parameter int ADDR_W   = 26,
  parameter int STEP_LSB = 22,
  parameter int NUM_BLK  = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       addr_valid,
  input logic [ADDR_W-1:0]          addr,
  input logic [ADDR_W-STEP_LSB-1:0] limit_code,
  input logic [1:0]                 mem_sel,
  input logic                       vbios_nc,
  input logic [NUM_BLK-1:0][7:0]    blk_ctl,
  input logic [NUM_BLK-1:0][7:0]    blk_base,
  input logic                       nc_pin_en,
  input logic                       out_valid,
  input logic                       nc_flag,
  input logic                       nc_n
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> out_valid); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |=> (!out_valid && $stable(nc_flag))); // R7
  AST_PIN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !nc_pin_en |-> nc_n); // R8
  AST_PIN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    nc_pin_en |-> (nc_n == !nc_flag)); // R8
  AST_ABOVE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && (mem_sel == 2'b00) && (limit_code != '0) &&
     (addr[ADDR_W-1:STEP_LSB] >= limit_code)) |=> nc_flag); // R1
  AST_VBIOS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && vbios_nc && (addr[ADDR_W-1:15] == 11'h018)) |=> nc_flag); // R3
  AST_BLOCK_BASE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && (blk_ctl[0][7:5] == 3'b000) &&
     (addr[ADDR_W-1:16] == {blk_ctl[0][1:0], blk_base[0]})) |=> nc_flag); // R5
endmodule

bind cache_region_decode cache_region_decode_chk #(
  .ADDR_W(ADDR_W), .STEP_LSB(STEP_LSB), .NUM_BLK(NUM_BLK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr(addr),
  .limit_code(limit_code), .mem_sel(mem_sel), .vbios_nc(vbios_nc),
  .blk_ctl(blk_ctl), .blk_base(blk_base), .nc_pin_en(nc_pin_en),
  .out_valid(out_valid), .nc_flag(nc_flag), .nc_n(nc_n)
);

// File: tb/sim_cache_region_decode.sv
module sim_cache_region_decode;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_valid = 1'b0;
  logic [25:0] addr = '0;
  logic [3:0] limit_code = '0;
  logic [1:0] mem_sel = '0;
  logic vbios_nc = 1'b0;
  logic [1:0][7:0] blk_ctl = {8'he0, 8'he0};
  logic [1:0][7:0] blk_base = '0;
  logic nc_pin_en = 1'b1;
  logic out_valid, nc_flag, nc_n;
  int checks = 0, errs = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cache_region_decode u0 (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr(addr),
    .limit_code(limit_code), .mem_sel(mem_sel), .vbios_nc(vbios_nc),
    .blk_ctl(blk_ctl), .blk_base(blk_base), .nc_pin_en(nc_pin_en),
    .out_valid(out_valid), .nc_flag(nc_flag), .nc_n(nc_n)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d addr=%h", req, act, exp, addr);
    end
  endtask

  function automatic bit blk_in(int page, logic [7:0] c, logic [7:0] b);
    int sz, base;
    if (c[7]) return 1'b0;
    sz = 1 << c[6:5];
    base = int'(c[1:0]) * 256 + int'(b);
    base = (base / sz) * sz;
    return (page >= base) && (page < base + sz);
  endfunction

  function automatic bit exp_nc();
    int page = int'(addr) / 65536;
    int lim;
    bit nc;
    if (mem_sel == 2'b01) lim = 16;
    else if (mem_sel == 2'b10) lim = 32;
    else if (limit_code == 0) lim = 1024;
    else lim = int'(limit_code) * 64;
    nc = page >= lim;
    if (vbios_nc && addr >= 26'hC0000 && addr < 26'hC8000) nc = 1'b1;
    if (blk_in(page, blk_ctl[0], blk_base[0])) nc = 1'b1;
    if (blk_in(page, blk_ctl[1], blk_base[1])) nc = 1'b1;
    return nc;
  endfunction

  task automatic apply(string req, logic [25:0] a, bit pen);
    bit e;
    @(negedge clk);
    addr = a; nc_pin_en = pen; addr_valid = 1'b1;
    e = exp_nc();
    @(posedge clk); #2;
    chk(req, int'(nc_flag), int'(e));
    chk("R7", int'(out_valid), 1);
    chk("R8", int'(nc_n), int'(!(e && pen)));
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #3;
    chk("R9", int'(out_valid), 0);
    chk("R9", int'(nc_flag), 0);
    chk("R9", int'(nc_n), 1);
    #20 rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R9", int'(nc_flag), 0);

    // R1 R2 R3: bound, installed memory and video window sweep
    for (int ms = 0; ms < 4; ms++)
      for (int code = 0; code < 16; code++)
        for (int pg = 0; pg < 1024; pg++) begin
          mem_sel = 2'(ms); limit_code = 4'(code);
          vbios_nc = code[1] ^ pg[0];
          apply((ms == 1 || ms == 2) ? "R2" : (pg == 12 ? "R3" : "R1"),
                26'(pg * 65536 + ((code + pg) % 2 == 0 ? 32'h4000 : 32'h8000)),
                pg[1]);
        end

    // R4 R5 R6: block size codes, alignment and two independent blocks
    mem_sel = 2'b00; limit_code = 4'd0; vbios_nc = 1'b0;
    for (int sc = 0; sc < 8; sc++)
      for (int v = 0; v < 3; v++) begin
        blk_ctl[0]  = {3'(sc), 3'b000, 2'(v + 1)};
        blk_base[0] = 8'hB7 ^ 8'(v * 8'h35);
        blk_ctl[1]  = {3'(7 - sc), 3'b000, 2'(v)};
        blk_base[1] = 8'h4B + 8'(v * 8'h22);
        for (int pg = 0; pg < 1024; pg++)
          apply(sc >= 4 ? "R4" : (v == 1 ? "R6" : "R5"), 26'(pg * 65536 + 1), 1'b1);
      end

    // R7: idle cycle keeps the flag
    blk_ctl = {8'he0, 8'he0}; limit_code = 4'd1;
    apply("R1", 26'h0800000, 1'b1);
    @(negedge clk);
    addr_valid = 1'b0; addr = 26'h0000100;
    @(posedge clk); #2;
    chk("R7", int'(nc_flag), 1);
    chk("R7", int'(out_valid), 0);
    // R8: pin masked while flag still set
    @(negedge clk); nc_pin_en = 1'b0; #1;
    chk("R8", int'(nc_n), 1);
    chk("R8", int'(nc_flag), 1);
    @(negedge clk); nc_pin_en = 1'b1; #1;
    chk("R8", int'(nc_n), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule